// File: doc/BRIEF.md
# Two-Channel Sample Gain/Offset Corrector with Ramp Test Source

This block conditions two synchronous streams of 8-bit two's-complement converter samples. Each channel has its own digital gain and offset coefficient, and the corrected sample is `sample × gain + offset`, rounded and then clamped to the 8-bit signed range. A small register write port loads the coefficients and a control word. The port clamps a gain or offset that lies outside the allowed calibration window, and it raises an error pulse when it does.

For bring-up, a test switch replaces the live converter samples with a shared ascending ramp. The ramp then passes through the same correction path. A per-channel enable mask decides which channels present a valid strobe at the output. One `in_valid` strobe qualifies both input lanes, and each output lane has its own valid bit. Both lanes share one clock and move through the same two-stage pipeline.

Gain is an unsigned fraction with 15 fractional bits, so 32768 means ×1.0. Offset is a signed count of quarter-LSB steps.

Top module: `adc_sample_cond`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_data` is 0 and `cfg_err` is 0. Each gain is 32768 (×1.0), each offset is 0, both channels are enabled and test mode is off, so samples then pass through unchanged.
- R2: For an input sample x (signed), gain g (unsigned, 15 fractional bits) and offset o (signed quarter-LSB count), the output is floor((x·g + o·8192 + 16384) / 32768), which rounds the exact result half-up.
- R3: A corrected result above +127 is output as +127 (0x7F), and a result below −128 is output as −128 (0x80).
- R4: A gain write outside 31130..34406 (0.95 to 1.05) stores the nearest limit. `cfg_err` is 1 in the cycle after such a write, and 0 after an in-range write.
- R5: An offset write (16-bit two's complement) outside −400..+400 stores the nearest limit, and `cfg_err` pulses as in R4.
- R6: Control bit 2 selects test mode. Each lane then carries the value of one shared 8-bit ramp, which starts at 0 after reset and advances by one per `in_valid` cycle only while test mode is on. It steps from 0x7F to 0x80, and the live inputs are ignored.
- R7: Control bits [1:0] enable channels 0 and 1. A disabled channel's `out_valid` bit stays 0.
- R8: A sample presented with `in_valid` at clock edge k appears with its `out_valid` bit at edge k+2. With no valid input, `out_valid` stays 0.
- R9: Register addresses: 0 is control, 2 is gain of channel 0, 3 is offset of channel 0, 4 is gain of channel 1, 5 is offset of channel 1. Writes to 1, 6 and 7 change nothing and do not raise `cfg_err`.
- R10: Each channel uses only its own coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both lanes |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (R9) |
| cfg_wdata | input | 16 | Register write data |
| cfg_err | output | 1 | One-cycle flag: the last write was clamped |
| in_valid | input | 1 | Qualifies both input lanes |
| in_data | input | 16 | Lane 0 in [7:0], lane 1 in [15:8] |
| out_valid | output | 2 | Per-lane output strobe |
| out_data | output | 16 | Corrected lane 0 in [7:0], lane 1 in [15:8] |

## Verification
The bench builds the block with its default parameters: two lanes, a 16-bit gain and a 10-bit offset. These values make the clamp limits, the full ±128 sample range and both saturation rails reachable with a few dozen samples. Because the ramp is 8 bits wide, a run of a few hundred test-mode samples carries it across the 0x7F to 0x80 step and back round through zero. The behavioural model recomputes every output from the written coefficients, which exposes rounding at exactly half an LSB for both positive and negative results.

// File: rtl/asc_pkg.sv
// Shared constants for the sample conditioner.
// Assumes: gain has GAIN_W-1 fractional bits; offset counts quarter LSBs.
package asc_pkg;
    localparam int GAIN_W    = 16;
    localparam int GAIN_ONE  = 32768;  // x1.0
    localparam int GAIN_MIN  = 31130;  // 0.95 rounded
    localparam int GAIN_MAX  = 34406;  // 1.05 rounded
    localparam int OFF_W     = 10;
    localparam int OFF_LIM   = 400;
    localparam int OFF_FRAC  = 2;      // quarter-LSB steps
    localparam int SAMPLE_W  = 8;
endpackage

// File: rtl/asc_coef_regs.sv
// Coefficient and control register bank.
// Does: decodes writes, clamps gain/offset into the calibration window,
// and flags a clamped write for one cycle.
// Assumes: a write lands at the clock edge where cfg_we is high.
module asc_coef_regs import asc_pkg::*; #(
    parameter int NCH = 2,
    parameter int GW  = GAIN_W,
    parameter int OW  = OFF_W,
    parameter int AW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [GW-1:0]     wdata,
    output logic [NCH*GW-1:0] gain_o,
    output logic [NCH*OW-1:0] off_o,
    output logic [NCH-1:0]    en_o,
    output logic              test_o,
    output logic              err_o
);
    localparam int FIRST_COEF = 2;
    localparam int LAST_COEF  = FIRST_COEF + 2*NCH - 1;

    logic [GW-1:0]        g_cl;
    logic                 g_bad;
    logic signed [OW-1:0] o_cl;
    logic                 o_bad;
    logic signed [GW-1:0] o_raw;
    logic                 coef_addr;
    logic [NCH:0]         ctrl_q;

    // Clamp the incoming gain into its window.
    always_comb begin
        g_bad = 1'b1;
        if (wdata < GW'(GAIN_MIN))      g_cl = GW'(GAIN_MIN);
        else if (wdata > GW'(GAIN_MAX)) g_cl = GW'(GAIN_MAX);
        else begin
            g_cl  = wdata;
            g_bad = 1'b0;
        end
    end

    // Clamp the incoming signed offset into +/- OFF_LIM.
    always_comb begin
        o_raw = $signed(wdata);
        o_bad = 1'b1;
        if (o_raw > GW'(OFF_LIM))       o_cl = OW'(OFF_LIM);
        else if (o_raw < -GW'(OFF_LIM)) o_cl = -OW'(OFF_LIM);
        else begin
            o_cl  = OW'(o_raw);
            o_bad = 1'b0;
        end
    end

    assign coef_addr = (int'(addr) >= FIRST_COEF) && (int'(addr) <= LAST_COEF);

    // Control word: lane enables and test switch.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl_q <= {1'b0, {NCH{1'b1}}};
        else if (we && addr == AW'(0))   ctrl_q <= wdata[NCH:0];
    end
    assign en_o   = ctrl_q[NCH-1:0];
    assign test_o = ctrl_q[NCH];

    // Error pulse for a clamped coefficient write.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= we && coef_addr && (addr[0] ? o_bad : g_bad);
    end

    a_r4_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(we));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [GW-1:0]        gain_q;
        logic signed [OW-1:0] off_q;

        // Per-lane gain register.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   gain_q <= GW'(GAIN_ONE);
            else if (we && addr == AW'(FIRST_COEF + 2*c)) gain_q <= g_cl;
        end

        // Per-lane offset register.
        always_ff @(posedge clk) begin
            if (!rst_n)                                       off_q <= '0;
            else if (we && addr == AW'(FIRST_COEF + 2*c + 1)) off_q <= o_cl;
        end

        assign gain_o[c*GW +: GW] = gain_q;
        assign off_o[c*OW +: OW]  = off_q;

        a_r4_gain_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            gain_q >= GW'(GAIN_MIN) && gain_q <= GW'(GAIN_MAX));
        a_r5_off_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            off_q >= -OW'(OFF_LIM) && off_q <= OW'(OFF_LIM));
    end
endmodule

// File: rtl/asc_ramp_gen.sv
// Shared ascending test ramp.
// Does: counts one step per valid input cycle while test mode is on.
// Assumes: natural 8-bit wrap gives the 0x7F -> 0x80 step.
module asc_ramp_gen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_i,
    input  logic          v_i,
    output logic [DW-1:0] ramp_o
);
    // Advance on each valid sample in test mode.
    always_ff @(posedge clk) begin
        if (!rst_n)              ramp_o <= '0;
        else if (test_i && v_i)  ramp_o <= ramp_o + DW'(1);
    end

    a_r6_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (test_i && v_i) |=> ramp_o == $past(ramp_o) + DW'(1));
    a_r6_ramp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_i && v_i) |=> $stable(ramp_o));
endmodule

// File: rtl/asc_lane.sv
// One lane of correction: capture, multiply-add, round, saturate.
// Does: two register stages; output valid gated by the lane enable.
// Assumes: gain is unsigned with GW-1 fraction bits, offset in quarter LSBs.
module asc_lane import asc_pkg::*; #(
    parameter int DW = SAMPLE_W,
    parameter int GW = GAIN_W,
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] x_i,
    input  logic          v_i,
    input  logic          en_i,
    input  logic [GW-1:0] gain_i,
    input  logic [OW-1:0] off_i,
    output logic [DW-1:0] y_o,
    output logic          v_o
);
    localparam int SW    = DW + GW + 2;
    localparam int FRAC  = GW - 1;
    localparam int OSH   = FRAC - OFF_FRAC;
    localparam int RND   = 1 << (FRAC - 1);
    localparam int YMAX  = (1 << (DW - 1)) - 1;
    localparam int YMIN  = -(1 << (DW - 1));

    logic [DW-1:0]        x_q;
    logic                 v_q;
    logic signed [SW-1:0] prod, acc, scaled;
    logic [DW-1:0]        y_d;

    // Stage 1: capture the selected sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            v_q <= 1'b0;
        end else begin
            x_q <= x_i;
            v_q <= v_i;
        end
    end

    // Multiply, add offset and half-LSB, scale back, saturate.
    always_comb begin
        prod   = SW'($signed(x_q)) * SW'($signed({1'b0, gain_i}));
        acc    = prod + (SW'($signed(off_i)) <<< OSH) + SW'(RND);
        scaled = acc >>> FRAC;
        if (scaled > SW'(YMAX))      y_d = DW'(YMAX);
        else if (scaled < SW'(YMIN)) y_d = DW'(YMIN);
        else                         y_d = scaled[DW-1:0];
    end

    // Stage 2: register result and gated valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o <= '0;
            v_o <= 1'b0;
        end else begin
            y_o <= y_d;
            v_o <= v_q && en_i;
        end
    end

    a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> $past(v_i, 2));
    a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> $past(en_i));
endmodule

// File: rtl/adc_sample_cond.sv
// Two-lane sample conditioner top.
// Does: selects live or ramp samples, corrects each lane with its own
// coefficients and gates each output valid with its enable bit.
// Assumes: both lanes share clk and a single input valid.
module adc_sample_cond import asc_pkg::*; #(
    parameter int NCH = 2,
    parameter int DW  = SAMPLE_W,
    parameter int GW  = GAIN_W,
    parameter int OW  = OFF_W,
    parameter int AW  = $clog2(2 + 2*NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [GW-1:0]     cfg_wdata,
    output logic              cfg_err,
    input  logic              in_valid,
    input  logic [NCH*DW-1:0] in_data,
    output logic [NCH-1:0]    out_valid,
    output logic [NCH*DW-1:0] out_data
);
    logic [NCH*GW-1:0] gain_w;
    logic [NCH*OW-1:0] off_w;
    logic [NCH-1:0]    en_w;
    logic              test_w;
    logic [DW-1:0]     ramp_w;

    asc_coef_regs #(.NCH(NCH), .GW(GW), .OW(OW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .gain_o(gain_w), .off_o(off_w),
        .en_o(en_w), .test_o(test_w), .err_o(cfg_err)
    );

    asc_ramp_gen #(.DW(DW)) u_ramp (
        .clk(clk), .rst_n(rst_n), .test_i(test_w), .v_i(in_valid),
        .ramp_o(ramp_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic [DW-1:0] x_sel;
        assign x_sel = test_w ? ramp_w : in_data[c*DW +: DW];

        asc_lane #(.DW(DW), .GW(GW), .OW(OW)) u_lane (
            .clk(clk), .rst_n(rst_n), .x_i(x_sel), .v_i(in_valid),
            .en_i(en_w[c]), .gain_i(gain_w[c*GW +: GW]),
            .off_i(off_w[c*OW +: OW]), .y_o(out_data[c*DW +: DW]),
            .v_o(out_valid[c])
        );
    end
endmodule

// File: tb/sim_adc_sample_cond.sv
module sim_adc_sample_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_err;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  out_valid;
    logic [15:0] out_data;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int sh_gain[2], sh_off[2];
    bit sh_en[2];
    bit sh_test;
    int m1_x[2];
    bit m1_v;
    bit m_ov[2];
    int m_od[2];
    logic [7:0] m_ramp;

    always #2 clk = ~clk;   // 250 MHz

    adc_sample_cond u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int corr(int x, int g, int o);
        int s;
        s = x * g + o * 8192 + 16384;
        s = s >>> 15;
        if (s > 127)  s = 127;
        if (s < -128) s = -128;
        return s;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            sh_gain = '{32768, 32768}; sh_off = '{0, 0};
            sh_en = '{1'b1, 1'b1}; sh_test = 1'b0;
            m1_x = '{0, 0}; m1_v = 1'b0; m_ov = '{1'b0, 1'b0};
            m_od = '{0, 0}; m_ramp = 8'h00;
        end else begin
            for (int c = 0; c < 2; c++) begin
                m_ov[c] = m1_v && sh_en[c];
                m_od[c] = corr(m1_x[c], sh_gain[c], sh_off[c]);
            end
            for (int c = 0; c < 2; c++)
                m1_x[c] = sh_test ? int'($signed(m_ramp)) : int'($signed(in_data[c*8 +: 8]));
            m1_v = in_valid;
            if (sh_test && in_valid) m_ramp = m_ramp + 8'd1;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(out_valid == 2'b00 && out_data == 16'h0 && cfg_err == 1'b0,
                    "R1", int'(out_valid), 0);
            end else begin
                chk(out_valid == {m_ov[1], m_ov[0]}, cur_req,
                    int'(out_valid), int'({m_ov[1], m_ov[0]}));
                for (int c = 0; c < 2; c++)
                    if (m_ov[c])
                        chk(int'($signed(out_data[c*8 +: 8])) == m_od[c], cur_req,
                            int'($signed(out_data[c*8 +: 8])), m_od[c]);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(int a, int b, bit v);
        @(posedge clk); #1;
        in_valid = v;
        in_data  = {8'(b), 8'(a)};
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send(0, 0, 1'b0);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d, string req);
        int exp_err, v, c;
        exp_err = 0;
        idle(3);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (a == 3'd0) begin
            sh_en[0] = d[0]; sh_en[1] = d[1]; sh_test = d[2];
        end else if (a >= 3'd2 && a <= 3'd5) begin
            c = (int'(a) - 2) / 2;
            if (!a[0]) begin
                v = int'(d);
                if (v < 31130) begin v = 31130; exp_err = 1; end
                if (v > 34406) begin v = 34406; exp_err = 1; end
                sh_gain[c] = v;
            end else begin
                v = int'($signed(d));
                if (v < -400) begin v = -400; exp_err = 1; end
                if (v > 400)  begin v = 400;  exp_err = 1; end
                sh_off[c] = v;
            end
        end
        @(negedge clk);
        chk(cfg_err == exp_err[0], req, int'(cfg_err), exp_err);
        @(negedge clk);
        chk(cfg_err == 1'b0, req, int'(cfg_err), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1/R2: unity pass-through over the full signed range
        cur_req = "R1_R2_unity";
        send(0, -1, 1); send(127, -128, 1); send(1, 64, 1); send(-77, 33, 1);
        idle(4);

        // R8: latency of exactly two edges
        cur_req = "R8_latency";
        send(5, 6, 1); send(0, 0, 0);
        @(negedge clk); chk(out_valid == 2'b00, "R8", int'(out_valid), 0);
        @(negedge clk); chk(out_valid == 2'b11, "R8", int'(out_valid), 3);
        chk(out_data == 16'h0605, "R8", int'(out_data), 16'h0605);
        idle(3);

        // R2/R10: different gains per lane
        wr(3'd2, 16'd34406, "R4");
        wr(3'd4, 16'd31130, "R4");
        cur_req = "R2_R10_gain";
        for (int i = -128; i < 128; i += 17) send(i, -i - 1, 1);
        idle(4);

        // R2: rounding at exactly half an LSB, both signs
        wr(3'd2, 16'd32768, "R4");
        wr(3'd4, 16'd32768, "R4");
        wr(3'd3, 16'd2, "R5");
        wr(3'd5, 16'hFFFE, "R5");
        cur_req = "R2_round";
        send(3, 3, 1); send(-3, -3, 1); send(0, 0, 1); send(-1, 1, 1);
        idle(4);

        // R3: saturation at both rails
        wr(3'd3, 16'd400, "R5");
        wr(3'd5, 16'hFE70, "R5");   // -400
        cur_req = "R3_saturate";
        send(100, -100, 1); send(27, -28, 1); send(28, -29, 1); send(-128, 127, 1);
        idle(4);

        // R4/R5: out-of-window writes clamp and flag
        wr(3'd2, 16'hFFFF, "R4");
        wr(3'd4, 16'd100, "R4");
        wr(3'd3, 16'd1000, "R5");
        wr(3'd5, 16'hFC18, "R5");    // -1000
        cur_req = "R4_R5_clamped_use";
        send(120, -120, 1); send(-50, 50, 1); send(10, -10, 1);
        idle(4);

        // R9: unused addresses change nothing
        wr(3'd1, 16'hFFFF, "R9");
        wr(3'd6, 16'h0000, "R9");
        wr(3'd7, 16'h8000, "R9");
        cur_req = "R9_unused_addr";
        send(120, -120, 1); send(-50, 50, 1);
        idle(4);

        // restore unity for the ramp
        wr(3'd2, 16'd32768, "R4"); wr(3'd3, 16'd0, "R5");
        wr(3'd4, 16'd32768, "R4"); wr(3'd5, 16'd0, "R5");

        // R6: ramp replaces live data, wraps 0x7F -> 0x80, holds on gaps
        wr(3'd0, 16'h0007, "R6");
        cur_req = "R6_ramp";
        for (int i = 0; i < 300; i++) send(55, -9, (i % 7) != 3);
        idle(4);
        wr(3'd0, 16'h0003, "R6");
        cur_req = "R6_ramp_off";
        send(11, 22, 1); send(-11, -22, 1);
        idle(4);

        // R7: enable mask
        wr(3'd0, 16'h0001, "R7");
        cur_req = "R7_mask_lane1";
        send(9, 9, 1); send(8, 8, 1);
        idle(4);
        wr(3'd0, 16'h0002, "R7");
        cur_req = "R7_mask_lane0";
        send(9, 9, 1); send(8, 8, 1);
        idle(4);
        wr(3'd0, 16'h0000, "R7");
        cur_req = "R7_mask_both";
        send(9, 9, 1); send(8, 8, 1);
        idle(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule